// File: doc/BRIEF.md
# Zero-Stuffing Frame Data Controller

This block feeds a fixed-size streaming FFT core that has been sized for the largest transform a system needs. It takes in a complex sample stream with a per-sample valid flag and a requested transform length. It then turns each sparse frame into a dense frame of exactly 2^MAX_LOG2 output cycles. Valid is asserted on every one of those cycles. Each accepted sample stays in the slot where it arrived, and every slot that carried no valid sample is replaced by a zero. A smaller transform of length N is therefore presented to the large core as the N-point sequence upsampled by 2^MAX_LOG2/N. This lets a single core serve every smaller size, and later logic picks out the bins it needs.

A frame opens on the first valid sample seen while the block is idle. That sample occupies slot 0. The requested length is captured on that same cycle and carried alongside the frame on its own output, together with a start marker on slot 0 and an end marker on the last slot. The supported lengths are the powers of two from 2^MIN_LOG2 to 2^MAX_LOG2. By default these are 128 to 2048, and any other request is replaced by the maximum. Every output lags its input by LAT cycles, 5 by default. Upstream logic must space the valid samples correctly (the factor 2^MAX_LOG2/N). The block neither checks nor buffers this spacing. Samples are signed DATA_W-bit values per part, Q2.14 by default.

Top module: `zs_frame_ctrl`

## Requirements
- R1: A valid input while idle opens a frame; out_valid is then high for exactly 2^MAX_LOG2 consecutive cycles, and afterwards stays low until another frame opens.
- R2: Every output field appears exactly LAT clock cycles after the input cycle that produced it (LAT = 5 by default).
- R3: A slot whose input valid is high carries that cycle's in_re and in_im unchanged to out_re and out_im.
- R4: A slot inside a frame whose input valid is low outputs zero on both out_re and out_im, whatever the data inputs hold.
- R5: out_start is high only on the first output cycle of a frame and out_end only on its last; both imply out_valid.
- R6: in_len is sampled only on the frame's first slot; out_len holds that value for the whole frame, and in_len values on later slots have no effect.
- R7: A requested length that is not a power of two between 2^MIN_LOG2 and 2^MAX_LOG2 is reported on out_len as 2^MAX_LOG2.
- R8: A valid input on the cycle right after a frame's last slot opens the next frame with no idle cycle between the two output frames.
- R9: While reset is held, and on the cycles after its release until a frame emerges, all outputs are low or zero.
- R10: While no frame is being output, out_re, out_im, out_start, out_end and out_len are zero, even when the data inputs are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_re | input | DATA_W | Real part of input sample, signed |
| in_im | input | DATA_W | Imaginary part of input sample, signed |
| in_len | input | LEN_W | Requested transform length, sampled on the opening slot |
| out_valid | output | 1 | Output slot belongs to a frame |
| out_start | output | 1 | First slot of a frame |
| out_end | output | 1 | Last slot of a frame |
| out_re | output | DATA_W | Real part of output, zero in empty slots |
| out_im | output | DATA_W | Imaginary part of output, zero in empty slots |
| out_len | output | LEN_W | Length captured for the frame, normalised |

## Verification
The bench builds the block with MAX_LOG2 = 4, MIN_LOG2 = 2 and LEN_W = 8, and keeps the default LAT of 5. Frames are then 16 slots long, and every supported length (4, 8, 16) fits in a few dozen cycles. Each slot of every frame can then be predicted and compared one by one. The small configuration allows a sweep of every requested length from 0 to 20, including the values that are not powers of two and the ones outside the range, each as its own frame. The sweep is combined with back-to-back frames, idle gaps carrying garbage data, and length changes on every slot after the first.

// File: rtl/zs_pkg.sv
package zs_pkg;
   typedef enum logic {
      ZS_IDLE  = 1'b0,
      ZS_FRAME = 1'b1
   } zs_state_e;

   // Field order of the payload carried through the latency line, MSB first:
   // valid, start, end, length, real, imaginary.
   localparam int ZS_FLAG_BITS = 3;
endpackage

// File: rtl/zs_slot_seq.sv
module zs_slot_seq
   import zs_pkg::*;
#(
   parameter int MAX_LOG2 = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   output logic slot_active,
   output logic slot_first,
   output logic slot_last
);
   localparam logic [MAX_LOG2-1:0] CNT_LAST = '1;
   localparam logic [MAX_LOG2-1:0] CNT_ONE  = MAX_LOG2'(1);

   zs_state_e             state;
   logic [MAX_LOG2-1:0]   slot_cnt;

   always_comb begin
      slot_first  = (state == ZS_IDLE) && in_valid;
      slot_active = (state == ZS_FRAME) || slot_first;
      slot_last   = (state == ZS_FRAME) && (slot_cnt == CNT_LAST);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ZS_IDLE;
         slot_cnt <= '0;
      end else if (slot_first) begin
         state    <= ZS_FRAME;
         slot_cnt <= CNT_ONE;
      end else if (state == ZS_FRAME) begin
         slot_cnt <= slot_cnt + 1'b1;
         if (slot_last) begin
            state <= ZS_IDLE;
         end
      end
   end
endmodule

// File: rtl/zs_len_norm.sv
module zs_len_norm #(
   parameter int LEN_W    = 16,
   parameter int MIN_LOG2 = 7,
   parameter int MAX_LOG2 = 11
) (
   input  logic [LEN_W-1:0] req_len,
   output logic [LEN_W-1:0] eff_len
);
   localparam int               N_SIZES = MAX_LOG2 - MIN_LOG2 + 1;
   localparam logic [LEN_W-1:0] MAX_VAL = LEN_W'(1) << MAX_LOG2;

   logic [N_SIZES-1:0] size_hit;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      localparam logic [LEN_W-1:0] SIZE_G = LEN_W'(1) << (MIN_LOG2 + g);
      assign size_hit[g] = (req_len == SIZE_G);
   end

   assign eff_len = (|size_hit) ? req_len : MAX_VAL;
endmodule

// File: rtl/zs_delay_line.sv
module zs_delay_line #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [WIDTH-1:0] stage [DEPTH];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
         end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
         end
      end

      assign q = stage[DEPTH-1];
   end
endmodule

// File: rtl/zs_frame_ctrl.sv
module zs_frame_ctrl
   import zs_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int LEN_W    = 16,
   parameter int MIN_LOG2 = 7,
   parameter int MAX_LOG2 = 11,
   parameter int LAT      = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   input  logic        [LEN_W-1:0]  in_len,
   output logic                     out_valid,
   output logic                     out_start,
   output logic                     out_end,
   output logic signed [DATA_W-1:0] out_re,
   output logic signed [DATA_W-1:0] out_im,
   output logic        [LEN_W-1:0]  out_len
);
   localparam int PAY_W = ZS_FLAG_BITS + LEN_W + 2 * DATA_W;

   if (LAT < 1) begin : g_bad_lat
      $error("zs_frame_ctrl: LAT must be at least 1");
   end
   if (MAX_LOG2 < 1 || MIN_LOG2 < 0 || MIN_LOG2 > MAX_LOG2) begin : g_bad_range
      $error("zs_frame_ctrl: need 0 <= MIN_LOG2 <= MAX_LOG2 and MAX_LOG2 >= 1");
   end
   if (LEN_W <= MAX_LOG2) begin : g_bad_len
      $error("zs_frame_ctrl: LEN_W too narrow for the largest length");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("zs_frame_ctrl: DATA_W must be at least 2");
   end

   logic              slot_active, slot_first, slot_last;
   logic [LEN_W-1:0]  len_norm, len_held, len_sel;
   logic              keep;
   logic [DATA_W-1:0] re_z, im_z;
   logic [PAY_W-1:0]  pay_d, pay_q;

   zs_slot_seq #(
      .MAX_LOG2 (MAX_LOG2)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .slot_active (slot_active),
      .slot_first  (slot_first),
      .slot_last   (slot_last)
   );

   zs_len_norm #(
      .LEN_W    (LEN_W),
      .MIN_LOG2 (MIN_LOG2),
      .MAX_LOG2 (MAX_LOG2)
   ) u_norm (
      .req_len (in_len),
      .eff_len (len_norm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         len_held <= '0;
      end else if (slot_first) begin
         len_held <= len_norm;
      end
   end

   always_comb begin
      keep    = slot_active && in_valid;
      re_z    = keep ? in_re : '0;
      im_z    = keep ? in_im : '0;
      len_sel = !slot_active ? '0 : (slot_first ? len_norm : len_held);
      pay_d   = {slot_active, slot_first, slot_last, len_sel, re_z, im_z};
   end

   zs_delay_line #(
      .WIDTH (PAY_W),
      .DEPTH (LAT)
   ) u_dly (
      .clk (clk),
      .rst (rst),
      .d   (pay_d),
      .q   (pay_q)
   );

   assign {out_valid, out_start, out_end, out_len, out_re, out_im} = pay_q;
endmodule

// File: rtl/zs_frame_ctrl_chk.sv
module zs_frame_ctrl_chk #(
   parameter int DATA_W   = 16,
   parameter int LEN_W    = 16,
   parameter int MIN_LOG2 = 7,
   parameter int MAX_LOG2 = 11,
   parameter int LAT      = 5
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     out_valid,
   input logic                     out_start,
   input logic                     out_end,
   input logic signed [DATA_W-1:0] out_re,
   input logic signed [DATA_W-1:0] out_im,
   input logic        [LEN_W-1:0]  out_len
);
   localparam logic [MAX_LOG2:0]  RUN_LAST = (MAX_LOG2+1)'((1 << MAX_LOG2) - 1);
   localparam logic [LEN_W-1:0]   MIN_VAL  = LEN_W'(1) << MIN_LOG2;
   localparam logic [LEN_W-1:0]   MAX_VAL  = LEN_W'(1) << MAX_LOG2;

   logic [MAX_LOG2:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
      end else if (out_valid) begin
         run_cnt <= out_end ? '0 : run_cnt + 1'b1;
      end else begin
         run_cnt <= '0;
      end
   end

   p_end_count_r1: assert property (@(posedge clk) disable iff (rst)
      out_end |-> (run_cnt == RUN_LAST));

   p_run_cont_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_end) |=> out_valid);

   p_start_fresh_r5: assert property (@(posedge clk) disable iff (rst)
      out_start |-> (run_cnt == '0));

   p_marks_valid_r5: assert property (@(posedge clk) disable iff (rst)
      (out_start || out_end) |-> out_valid);

   p_len_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_start) |-> (out_len == $past(out_len)));

   p_len_legal_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($countones(out_len) == 1 && out_len >= MIN_VAL && out_len <= MAX_VAL));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_re == '0 && out_im == '0 && !out_start && !out_end && out_len == '0));
endmodule

bind zs_frame_ctrl zs_frame_ctrl_chk #(
   .DATA_W   (DATA_W),
   .LEN_W    (LEN_W),
   .MIN_LOG2 (MIN_LOG2),
   .MAX_LOG2 (MAX_LOG2),
   .LAT      (LAT)
) u_zs_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_start (out_start),
   .out_end   (out_end),
   .out_re    (out_re),
   .out_im    (out_im),
   .out_len   (out_len)
);

// File: tb/tb_zs_frame_ctrl.sv
`timescale 1ns/1ps
module tb_zs_frame_ctrl;
   localparam int DW   = 16;
   localparam int LW   = 8;
   localparam int MINL = 2;
   localparam int MAXL = 4;
   localparam int LAT  = 5;
   localparam int FLEN = 1 << MAXL;
   localparam int NC   = 560;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_re = '0, in_im = '0;
   logic        [LW-1:0] in_len = '0;
   logic                 out_valid, out_start, out_end;
   logic signed [DW-1:0] out_re, out_im;
   logic        [LW-1:0] out_len;

   always #4 clk = ~clk;

   zs_frame_ctrl #(
      .DATA_W(DW), .LEN_W(LW), .MIN_LOG2(MINL), .MAX_LOG2(MAXL), .LAT(LAT)
   ) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .in_len(in_len), .out_valid(out_valid), .out_start(out_start),
      .out_end(out_end), .out_re(out_re), .out_im(out_im), .out_len(out_len)
   );

   // stimulus per input cycle
   logic          s_v  [NC];
   logic [DW-1:0] s_re [NC];
   logic [DW-1:0] s_im [NC];
   logic [LW-1:0] s_len[NC];
   // expectation per input cycle (seen LAT cycles later)
   logic          e_v  [NC];
   logic          e_s  [NC];
   logic          e_e  [NC];
   logic          e_b2b[NC];
   logic          e_dat[NC];
   logic          e_sup[NC];
   logic [DW-1:0] e_re [NC];
   logic [DW-1:0] e_im [NC];
   logic [LW-1:0] e_len[NC];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input int cyc,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   function automatic bit supported(input int l);
      for (int k = MINL; k <= MAXL; k++) if (l == (1 << k)) return 1;
      return 0;
   endfunction

   task automatic add_frame(input int s, input int lreq, input bit b2b);
      int eff, step;
      eff  = supported(lreq) ? lreq : FLEN;
      step = FLEN / eff;
      for (int j = 0; j < FLEN; j++) begin
         int c;
         c = s + j;
         s_v[c]   = (j % step) == 0;
         s_len[c] = (j == 0) ? LW'(lreq) : LW'(j * 3 + 1);
         e_v[c]   = 1'b1;
         e_s[c]   = (j == 0);
         e_e[c]   = (j == FLEN - 1);
         e_b2b[c] = b2b && (j == 0);
         e_dat[c] = s_v[c];
         e_sup[c] = supported(lreq);
         e_re[c]  = s_v[c] ? s_re[c] : '0;
         e_im[c]  = s_v[c] ? s_im[c] : '0;
         e_len[c] = LW'(eff);
      end
   endtask

   initial begin
      #(50000 * 8);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         s_v[c]   = 1'b0;
         s_re[c]  = DW'((c * 37 + 5) | 1);
         s_im[c]  = DW'(-(c * 53 + 9));
         s_len[c] = LW'(c * 7);
         e_v[c] = 0; e_s[c] = 0; e_e[c] = 0; e_b2b[c] = 0; e_dat[c] = 0; e_sup[c] = 0;
         e_re[c] = '0; e_im[c] = '0; e_len[c] = '0;
      end
      add_frame(2,   16, 1'b0);
      add_frame(18,  4,  1'b1);   // R8 back-to-back
      add_frame(40,  8,  1'b0);
      add_frame(60,  5,  1'b0);   // R7 not a power of two
      add_frame(80,  0,  1'b0);   // R7 zero
      add_frame(100, 2,  1'b0);   // R7 below minimum
      for (int k = 0; k <= 20; k++) add_frame(120 + k * 20, k, 1'b0);

      // R9: reset state
      repeat (3) begin
         @(negedge clk);
         chk(!out_valid && !out_start && !out_end && out_re == 0 && out_im == 0 && out_len == 0,
             "R9", -1, {out_valid, out_start, out_end}, 0);
      end
      rst = 1'b0;

      for (int c = 0; c < NC; c++) begin
         @(negedge clk);
         if (c >= LAT) begin
            int p;
            p = c - LAT;
            chk(out_valid == e_v[p], e_b2b[p] ? "R8 R1" : (e_v[p] ? "R1" : "R1 R10"),
                p, out_valid, e_v[p]);
            if (e_v[p]) begin
               chk(out_re == e_re[p] && out_im == e_im[p], e_dat[p] ? "R2 R3" : "R4",
                   p, out_re, e_re[p]);
               chk(out_start == e_s[p] && out_end == e_e[p], "R5",
                   p, {out_start, out_end}, {e_s[p], e_e[p]});
               chk(out_len == e_len[p], e_sup[p] ? "R6" : "R7", p, out_len, e_len[p]);
            end else begin
               chk(out_re == 0 && out_im == 0 && !out_start && !out_end && out_len == 0,
                   "R10", p, out_re, 0);
            end
         end
         in_valid = s_v[c];
         in_re    = s_re[c];
         in_im    = s_im[c];
         in_len   = s_len[c];
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule